// File: doc/BRIEF.md
# Two-Class Programmable Priority Resolver

The resolver takes a software-loaded priority table of 40 slots. Each slot holds a valid flag and a 6-bit source number. The block searches that table for the most urgent source that is currently active, and it does this twice in parallel: once for sources marked as fast-class and once for the remaining normal-class sources. Slot 0 is the most urgent. The order in which sources are served therefore depends only on which source number software places in which slot, and not on where a source sits in the input vectors.

The block has three input vectors, one bit per source: an active vector (already pending and enabled), a class vector, and the table itself, given as a per-slot valid vector plus a flat bus of source numbers. The two winners are packed into one 32-bit status word. That word is registered, so it shows the inputs that were present at the previous clock edge. Register decoding, masking and interrupt line generation sit outside this block.

Top module: `prio_resolver`

## Requirements
- R1: While reset is asserted and on release, `winner_o` reads 0x003F003F.
- R2: A slot whose valid flag is clear never contributes a winner, even if its source is active.
- R3: A slot whose source number is 40 or above is skipped, and a reported winner number is always below 40.
- R4: In each class, among slots that are valid, in range and name an active source of that class, the lowest-numbered slot decides the winner.
- R5: The fast winner's source number appears in bits 5:0, and bit 15 is set when a fast winner exists.
- R6: The normal winner's source number appears in bits 21:16, and bit 31 is set when a normal winner exists.
- R7: A class with no winner reads source number 0x3F in its field with its flag clear.
- R8: An active source whose class bit is 1 is eligible only for the fast result. One whose class bit is 0 is eligible only for the normal result.
- R9: Bits 14:6 and 30:22 of `winner_o` are always zero.
- R10: `winner_o` reflects the inputs sampled at the previous rising clock edge, one cycle of latency.
- R11: An active source that no valid slot names is never reported. When a source number is named by several slots, the earliest such slot decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_active | input | 40 | Bit s set when source s is pending and enabled |
| src_fast | input | 40 | Bit s set when source s belongs to the fast class |
| ent_valid | input | 40 | Bit k set when priority slot k is in use |
| ent_src | input | 240 | Slot k's source number in bits 6k+5:6k |
| winner_o | output | 32 | Registered packed status word |

## Verification
The bench goes after the cases a resolver tends to get wrong. One is slot order versus source order: with a reversed table, a design that picks by source index reports the wrong source. Another is a cleared valid flag or a source number of 40 to 63 sitting in a high-priority slot; a design that skips those checks reports a phantom or out-of-range source and shadows the real winner. It also checks fast and normal sources that are active together, where mixing up the class routing puts a source in the wrong half or drops one of the two flags. Finally, back-to-back changes each cycle show whether the one-cycle latency holds, and an idle table shows whether the 0x3F filler and the zero spare bits are right.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NUM_SRC   = 40,
  parameter int ID_W      = 6,
  parameter int FAST_FLAG = 15,
  parameter int NORM_LSB  = 16,
  parameter int NORM_FLAG = 31
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      src_active,
  input  logic [NUM_SRC-1:0]      src_fast,
  input  logic [NUM_SRC-1:0]      ent_valid,
  input  logic [NUM_SRC*ID_W-1:0] ent_src,
  output logic [31:0]             winner_o
);

  localparam logic [ID_W:0]   SRC_LIM   = (ID_W+1)'(NUM_SRC);
  localparam logic [ID_W-1:0] NO_ID     = '1;
  localparam logic [31:0]     IDLE_WORD = 32'(NO_ID) | (32'(NO_ID) << NORM_LSB);

  logic [NUM_SRC-1:0] act_fast, act_norm;
  logic [NUM_SRC-1:0] hit_fast, hit_norm;
  logic [ID_W-1:0]    f_id, n_id;
  logic               f_hit, n_hit;
  logic [31:0]        nxt_word;

  assign act_fast = src_active & src_fast;
  assign act_norm = src_active & ~src_fast;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    logic [ID_W-1:0] sid;
    logic            ok;
    assign sid         = ent_src[g*ID_W +: ID_W];
    assign ok          = ent_valid[g] && ({1'b0, sid} < SRC_LIM);
    assign hit_fast[g] = ok && act_fast[sid];
    assign hit_norm[g] = ok && act_norm[sid];
  end

  always_comb begin
    f_hit = 1'b0;
    n_hit = 1'b0;
    f_id  = NO_ID;
    n_id  = NO_ID;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (hit_fast[i]) begin
        f_hit = 1'b1;
        f_id  = ent_src[i*ID_W +: ID_W];
      end
      if (hit_norm[i]) begin
        n_hit = 1'b1;
        n_id  = ent_src[i*ID_W +: ID_W];
      end
    end
  end

  always_comb begin
    nxt_word                     = '0;
    nxt_word[ID_W-1:0]           = f_id;
    nxt_word[FAST_FLAG]          = f_hit;
    nxt_word[NORM_LSB +: ID_W]   = n_id;
    nxt_word[NORM_FLAG]          = n_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) winner_o <= IDLE_WORD;
    else        winner_o <= nxt_word;
  end

  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    winner_o[FAST_FLAG-1:ID_W] == '0 && winner_o[NORM_FLAG-1:NORM_LSB+ID_W] == '0);

  assert_fast_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !winner_o[FAST_FLAG] |-> winner_o[ID_W-1:0] == NO_ID);

  assert_norm_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !winner_o[NORM_FLAG] |-> winner_o[NORM_LSB +: ID_W] == NO_ID);

  assert_fast_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    winner_o[FAST_FLAG] |-> {1'b0, winner_o[ID_W-1:0]} < SRC_LIM);

  assert_norm_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    winner_o[NORM_FLAG] |-> {1'b0, winner_o[NORM_LSB +: ID_W]} < SRC_LIM);

  assert_fast_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    winner_o[FAST_FLAG] |->
      |($past(act_fast) & (NUM_SRC'(1) << winner_o[ID_W-1:0])));

  assert_norm_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    winner_o[NORM_FLAG] |->
      |($past(act_norm) & (NUM_SRC'(1) << winner_o[NORM_LSB +: ID_W])));

endmodule

// File: tb/prio_resolver_test.sv
module prio_resolver_test;
  localparam int N = 40;
  localparam int W = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src_active = '0;
  logic [N-1:0]   src_fast = '0;
  logic [N-1:0]   ent_valid = '0;
  logic [N*W-1:0] ent_src = '0;
  logic [31:0]    winner_o;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;

  logic [W-1:0] tid [N];
  bit           tval[N];

  always #4 clk = ~clk;

  prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .src_active(src_active), .src_fast(src_fast),
    .ent_valid(ent_valid), .ent_src(ent_src), .winner_o(winner_o)
  );

  function automatic logic [31:0] model(input logic [N-1:0] act, input logic [N-1:0] fst);
    logic [31:0] w;
    bit fdone, ndone;
    w = 32'h003F003F;
    fdone = 0;
    ndone = 0;
    for (int k = 0; k < N; k++) begin
      if (tval[k] && tid[k] < N && act[tid[k]]) begin
        if (fst[tid[k]] && !fdone) begin
          fdone = 1; w[15:0] = 16'h8000 | 16'(tid[k]);
        end
        if (!fst[tid[k]] && !ndone) begin
          ndone = 1; w[31:16] = 16'h8000 | 16'(tid[k]);
        end
      end
    end
    return w;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] act, input logic [N-1:0] fst, input string tag);
    item_t it;
    @(negedge clk);
    src_active = act;
    src_fast   = fst;
    for (int k = 0; k < N; k++) begin
      ent_valid[k]       = tval[k];
      ent_src[k*W +: W]  = tid[k];
    end
    it.exp = model(act, fst);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic table_identity();
    for (int k = 0; k < N; k++) begin tid[k] = W'(k); tval[k] = 1; end
  endtask

  task automatic table_reverse();
    for (int k = 0; k < N; k++) begin tid[k] = W'(N-1-k); tval[k] = 1; end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(winner_o, it.exp, it.tag);
    end
  end

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog expired got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] one;
    table_identity();
    repeat (3) @(posedge clk);
    #1 check(winner_o, 32'h003F003F, "R1 reset word");
    @(negedge clk) rst_n = 1'b1;
    #1 check(winner_o, 32'h003F003F, "R1 after release");

    one = '0; one[10] = 1'b1;
    drive(one, '0, "R6 normal field layout");
    drive(one, one, "R5 fast field layout");
    drive('0, '0, "R7 nothing active");

    table_reverse();
    one = '0; one[3] = 1'b1; one[30] = 1'b1;
    drive(one, '0, "R4 slot order not source order");
    drive(one, N'(1) << 3, "R8 split classes");
    drive(one, one, "R4 fast both");
    tval[9] = 0;
    drive(N'(1) << 30, '0, "R2 invalid slot ignored");
    table_reverse();

    tid[0] = 6'd45; tid[1] = 6'd40; tid[2] = 6'd63;
    drive('1, '0, "R3 out of range skipped");
    drive('1, '1, "R3 out of range fast");

    table_identity();
    for (int k = 20; k < N; k++) tval[k] = 0;
    drive(N'(1) << 25, '0, "R11 unnamed source");
    for (int k = 0; k < N; k++) begin tid[k] = 6'd12; tval[k] = (k >= 7); end
    drive(N'(1) << 12, '0, "R11 duplicate names");
    tid[7] = 6'd50; tid[8] = 6'd33;
    drive((N'(1) << 12) | (N'(1) << 33), N'(1) << 33, "R11 first qualifying slot");

    table_identity();
    drive('1, {20{2'b10}}, "R9 spare bits all active");
    for (int c = 0; c < 6; c++)
      drive(N'(1) << (c*7), (c % 2 == 0) ? '1 : '0, "R10 back to back");

    for (int r = 0; r < 150; r++) begin
      for (int k = 0; k < N; k++) begin
        tid[k]  = W'($urandom_range(0, 47));
        tval[k] = ($urandom_range(0, 3) != 0);
      end
      drive({$urandom, $urandom} & {$urandom, $urandom}, {$urandom, $urandom}, "R4 random table");
    end

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule